// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called side A and side B, and can pass data in either direction. Each side has its own holding register with its own capture clock, so a snapshot of either bus can be kept while the buses go on changing. For each direction a select input picks the source of the driven side. It is either the live value on the opposite bus or the value last stored from the opposite bus. Data is never inverted.

An active-low enable and a direction input decide which side, if either, the block drives. Each bidirectional bus is split into an input vector, an output vector and an output-enable vector, so the core holds no tri-state logic. A wrapper at the pads resolves each bus and feeds the resolved value back into the matching input vector. Both registers capture on every rising edge of their own clock, whatever the enable, direction and select inputs are set to, and also while the outputs are isolated. Each register has a synchronous active-high reset, applied on an edge of that register's own clock.

Top module: `reg_bus_xcvr`

## Requirements
- R1: On every rising edge of `clk_a_cap` with `rst` low, the A holding register takes the value of `a_in`. An edge of `clk_b_cap` leaves it unchanged.
- R2: On every rising edge of `clk_b_cap` with `rst` low, the B holding register takes the value of `b_in`. An edge of `clk_a_cap` leaves it unchanged.
- R3: Capture does not depend on `en_n`, `dir_b`, `sel_a_stored` or `sel_b_stored`. Capture also works while the outputs are isolated, and on a side the block is driving it stores the resolved (driven) value.
- R4: While `en_n` is 1, both `a_oe` and `b_oe` are all zeros.
- R5: While `en_n` is 0, `dir_b` = 0 makes `a_oe` all ones and `b_oe` all zeros, and `dir_b` = 1 makes `b_oe` all ones and `a_oe` all zeros. The output enables are never partly set, and the two sides are never enabled together.
- R6: `a_out` equals `b_in` when `sel_a_stored` = 0, and equals the B holding register when `sel_a_stored` = 1.
- R7: `b_out` equals `a_in` when `sel_b_stored` = 0, and equals the A holding register when `sel_b_stored` = 1.
- R8: If `rst` is 1 at a rising edge of a register's clock, that register becomes all zeros. Stored transfers then output zeros until the next capture.
- R9: The path is bit-for-bit and non-inverting: bit n of one side drives bit n of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a_cap | input | 1 | Capture clock of the A holding register |
| clk_b_cap | input | 1 | Capture clock of the B holding register |
| rst | input | 1 | Synchronous active-high reset, applied on each register's own clock |
| en_n | input | 1 | Active-low output enable (1 = isolate both sides) |
| dir_b | input | 1 | Direction: 0 drives side A, 1 drives side B |
| sel_a_stored | input | 1 | Source for side A: 0 = live `b_in`, 1 = B holding register |
| sel_b_stored | input | 1 | Source for side B: 0 = live `a_in`, 1 = A holding register |
| a_in | input | W | Resolved value of bus A |
| a_out | output | W | Value offered to bus A |
| a_oe | output | W | Per-bit drive enable of bus A |
| b_in | input | W | Resolved value of bus B |
| b_out | output | W | Value offered to bus B |
| b_oe | output | W | Per-bit drive enable of bus B |

## Verification
All sixteen settings of enable, direction and the two selects are swept for each of several data words. The words are walking ones, all zeros, all ones and an alternating pattern. Between capture and check, the live inputs are loaded with values that differ from the stored ones, so every bit tells a live transfer from a stored one, and every mode can be told from the others. Walking ones expose any swapped or inverted bit. Single-clock pulses, while the other register stays put, show that the two registers are independent. Captures taken while the outputs are isolated, and taken from a bus the block itself drives, show that capture ignores the control inputs.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_A    = 2'd1,
        SIDE_B    = 2'd2
    } drive_side_e;

    typedef struct packed {
        logic en_n;
        logic dir_b;
    } drive_ctl_t;

    function automatic drive_side_e side_of(input drive_ctl_t c);
        if (c.en_n)
            return SIDE_NONE;
        else if (c.dir_b)
            return SIDE_B;
        else
            return SIDE_A;
    endfunction

endpackage

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end

endmodule

// File: rtl/xcvr_src_mux.sv
module xcvr_src_mux #(
    parameter int W = 8
) (
    input  logic         use_stored,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);

    always_comb begin
        y = use_stored ? stored : live;
    end

endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl #(
    parameter int W = 8
) (
    input  logic         en_n,
    input  logic         dir_b,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_oe
);
    import xcvr_pkg::*;

    drive_ctl_t  ctl;
    drive_side_e side;
    logic        drv_a;
    logic        drv_b;

    always_comb begin
        ctl.en_n  = en_n;
        ctl.dir_b = dir_b;
        side      = side_of(ctl);
        drv_a     = (side == SIDE_A);
        drv_b     = (side == SIDE_B);
    end

    for (genvar g = 0; g < W; g++) begin : g_oe
        assign a_oe[g] = drv_a;
        assign b_oe[g] = drv_b;
    end

endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr #(
    parameter int W = xcvr_pkg::DATA_W
) (
    input  logic         clk_a_cap,
    input  logic         clk_b_cap,
    input  logic         rst,
    input  logic         en_n,
    input  logic         dir_b,
    input  logic         sel_a_stored,
    input  logic         sel_b_stored,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);

    logic [W-1:0] hold_a;
    logic [W-1:0] hold_b;

    // Captures run on their own clocks regardless of the drive controls.
    xcvr_hold_reg #(.W(W)) u_hold_a (
        .clk (clk_a_cap),
        .rst (rst),
        .d   (a_in),
        .q   (hold_a)
    );

    xcvr_hold_reg #(.W(W)) u_hold_b (
        .clk (clk_b_cap),
        .rst (rst),
        .d   (b_in),
        .q   (hold_b)
    );

    // Side A is fed from side B (live or stored), and the reverse.
    xcvr_src_mux #(.W(W)) u_mux_to_a (
        .use_stored (sel_a_stored),
        .live       (b_in),
        .stored     (hold_b),
        .y          (a_out)
    );

    xcvr_src_mux #(.W(W)) u_mux_to_b (
        .use_stored (sel_b_stored),
        .live       (a_in),
        .stored     (hold_a),
        .y          (b_out)
    );

    xcvr_drive_ctl #(.W(W)) u_drive (
        .en_n  (en_n),
        .dir_b (dir_b),
        .a_oe  (a_oe),
        .b_oe  (b_oe)
    );

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int W = 8
) (
    input logic         clk_a,
    input logic         clk_b,
    input logic         rst,
    input logic         en_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_oe,
    input logic [W-1:0] hold_a,
    input logic [W-1:0] hold_b
);

    p_capture_a_r1: assert property (@(posedge clk_a) disable iff (rst)
        !rst |=> hold_a == $past(a_in))
        else $error("capture A mismatch");

    p_capture_b_r2: assert property (@(posedge clk_b) disable iff (rst)
        !rst |=> hold_b == $past(b_in))
        else $error("capture B mismatch");

    p_reset_a_r8: assert property (@(posedge clk_a)
        rst |=> hold_a == '0)
        else $error("reset A not cleared");

    p_reset_b_r8: assert property (@(posedge clk_b)
        rst |=> hold_b == '0)
        else $error("reset B not cleared");

    p_isolate_r4: assert property (@(posedge clk_a) disable iff (rst)
        en_n |-> (a_oe == '0 && b_oe == '0))
        else $error("driven while isolated");

    p_one_side_r5: assert property (@(posedge clk_a) disable iff (rst)
        !((|a_oe) && (|b_oe)))
        else $error("both sides driven");

    p_whole_bus_r5: assert property (@(posedge clk_a) disable iff (rst)
        (a_oe == '0 || a_oe == '1) && (b_oe == '0 || b_oe == '1))
        else $error("partial output enable");

endmodule

bind reg_bus_xcvr xcvr_checker #(.W(W)) u_chk (
    .clk_a  (clk_a_cap),
    .clk_b  (clk_b_cap),
    .rst    (rst),
    .en_n   (en_n),
    .a_in   (a_in),
    .b_in   (b_in),
    .a_oe   (a_oe),
    .b_oe   (b_oe),
    .hold_a (hold_a),
    .hold_b (hold_b)
);

// File: tb/sim_reg_bus_xcvr.sv
module sim_reg_bus_xcvr;

    localparam int  W          = 8;
    localparam time CLK_PERIOD = 10;

    logic         clk_a_cap = 0, clk_b_cap = 0, rst = 0;
    logic         en_n = 1, dir_b = 0, sel_a_stored = 0, sel_b_stored = 0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    logic [W-1:0] ma, mb;
    int checks = 0, errors = 0;
    bit done = 0;

    reg_bus_xcvr #(.W(W)) u0 (
        .clk_a_cap, .clk_b_cap, .rst, .en_n, .dir_b,
        .sel_a_stored, .sel_b_stored,
        .a_in, .a_out, .a_oe, .b_in, .b_out, .b_oe
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic pulse_a();
        #(CLK_PERIOD/2) clk_a_cap = 1;
        ma = rst ? '0 : a_in;
        #(CLK_PERIOD/2) clk_a_cap = 0;
    endtask

    task automatic pulse_b();
        #(CLK_PERIOD/2) clk_b_cap = 1;
        mb = rst ? '0 : b_in;
        #(CLK_PERIOD/2) clk_b_cap = 0;
    endtask

    task automatic set_mode(input logic g, input logic d, input logic sa, input logic sb);
        en_n = g; dir_b = d; sel_a_stored = sa; sel_b_stored = sb;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] pats [11];
        ma = 'x; mb = 'x;
        // R8: reset clears both registers
        a_in = 8'h3C; b_in = 8'hC3; rst = 1;
        pulse_a(); pulse_b();
        rst = 0;
        set_mode(0, 0, 1, 1);
        chk("R8 reset A side stored out", a_out, 8'h00);
        chk("R8 reset B side stored out", b_out, 8'h00);
        chk("R5 a_oe after reset", a_oe, 8'hFF);
        chk("R5 b_oe after reset", b_oe, 8'h00);

        for (int i = 0; i < 8; i++) pats[i] = 8'(1 << i);
        pats[8] = 8'h00; pats[9] = 8'hFF; pats[10] = 8'hA5;

        for (int p = 0; p < 11; p++) begin
            a_in = pats[p]; b_in = ~pats[p] ^ 8'h5A;
            set_mode(1, 0, 0, 0);
            pulse_a(); pulse_b();
            // change live inputs so live and stored differ in every bit
            a_in = ~ma; b_in = ~mb;
            for (int m = 0; m < 16; m++) begin
                logic g, d, sa, sb;
                g = m[3]; d = m[2]; sa = m[1]; sb = m[0];
                set_mode(g, d, sa, sb);
                chk("R4/R5 a_oe", a_oe, (!g && !d) ? 8'hFF : 8'h00);
                chk("R4/R5 b_oe", b_oe, (!g && d) ? 8'hFF : 8'h00);
                chk("R6 R9 a_out", a_out, sa ? mb : b_in);
                chk("R7 R9 b_out", b_out, sb ? ma : a_in);
            end
        end

        // R1: clk_a only moves the A register
        set_mode(0, 1, 1, 1);
        a_in = 8'h11; b_in = 8'h22; pulse_a(); pulse_b();
        a_in = 8'h99; b_in = 8'h77; pulse_a();
        chk("R1 A captured on its clock", b_out, 8'h99);
        chk("R2 B unchanged by clk_a", a_out, 8'h22);
        // R2: clk_b only moves the B register
        a_in = 8'h44; b_in = 8'hEE; pulse_b();
        chk("R2 B captured on its clock", a_out, 8'hEE);
        chk("R1 A unchanged by clk_b", b_out, 8'h99);

        // R3: capture while isolated
        set_mode(1, 0, 1, 1);
        a_in = 8'h6B; b_in = 8'hD2; pulse_a(); pulse_b();
        set_mode(0, 1, 1, 1);
        chk("R3 A captured while isolated", b_out, 8'h6B);
        chk("R3 B captured while isolated", a_out, 8'hD2);

        // R3: capture of a driven bus stores the driven value
        set_mode(0, 0, 1, 0);
        a_in = a_out;          // wrapper resolves bus A to the driven value
        pulse_a();
        set_mode(0, 1, 0, 1);
        chk("R3 A stores its own driven value", b_out, 8'hD2);

        // R8: reset on clk_a only clears A
        rst = 1; pulse_a(); rst = 0;
        set_mode(0, 1, 1, 1);
        chk("R8 A cleared by reset", b_out, 8'h00);
        chk("R8 B kept without its clock", a_out, 8'hD2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule